// File: doc/BRIEF.md
# Transmit Word-to-Byte Lane Multiplexer

This block sits on one transmit channel between the fabric logic and a byte-wide encoder that runs at four times the fabric word rate. On every fabric-clock cycle with `wr_valid` high, it accepts a 32-bit data word. Each of the four bytes in that word comes with a control-character flag and a force-negative-disparity flag. The block stores the word in an eight-entry FIFO whose pointers are Gray coded, so the word can cross from the fabric clock into the byte clock.

On the byte side, a two-bit phase counter picks one byte per byte-clock cycle. It puts that byte and its two flags onto a 10-bit lane. When no word is waiting at a word boundary, the lane carries the idle control character. Each domain has its own asynchronous active-low reset, and that reset is released in step with its own clock. Two sticky flags record words that were dropped on overflow and gaps in the outgoing stream.

Top module: `txm_word_to_byte`

## Requirements
- R1: Each word is sent most significant byte first: bits [31:24], then [23:16], then [15:8], then [7:0]. The first byte goes out with flag bit 3 of both flag vectors, and the last byte goes out with flag bit 0.
- R2: The lane carries the data byte in bits [7:0], the control-character flag in bit 8 and the force-negative-disparity flag in bit 9.
- R3: Every accepted word produces exactly four consecutive lanes. Words are sent in the order they were written. Words written on consecutive fabric cycles produce a stream with no idle lanes between them.
- R4: When the FIFO is empty at a word boundary, the next lane is the idle character 10'h1BC (bit 9 = 0, bit 8 = 1, byte 0xBC).
- R5: While the byte-side reset is applied, the lane shows the idle character. After reset, the first word starts on a word boundary with its first byte.
- R6: The FIFO holds 8 words. A write while the FIFO is full is dropped, and it sets `ovf_flag`, which stays set until the fabric-side reset.
- R7: `udf_flag` sets when the FIFO is found empty at the boundary right after a word's last byte. It stays set until the byte-side reset. It does not set before the first word or while words arrive back to back.
- R8: Both `ovf_flag` and `udf_flag` are 0 after their domain's reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Fabric word clock |
| wr_arst_n | input | 1 | Fabric-side asynchronous reset, active low |
| wr_valid | input | 1 | Word present this fabric cycle |
| wr_data | input | 32 | Four data bytes |
| wr_ctl | input | 4 | Control-character flag per byte |
| wr_fnd | input | 4 | Force-negative-disparity flag per byte |
| byte_clk | input | 1 | Byte clock, four times the word clock |
| byte_arst_n | input | 1 | Byte-side asynchronous reset, active low |
| lane_out | output | 10 | {force-neg flag, control flag, byte} |
| ovf_flag | output | 1 | Sticky: write dropped while FIFO full |
| udf_flag | output | 1 | Sticky: stream gap after a word |

## Verification
The assertions check the following on every cycle:
- the idle character follows an empty word boundary;
- the phase counter steps once per byte inside a word;
- a write while the FIFO is full leaves the write pointer unchanged;
- both error flags stay set once raised.

Only the bench scenarios can show the rest: byte order, flag pairing, gap-free back-to-back streaming across the clock crossing, and exactly which eight words survive a ninth write into a full FIFO.

// File: rtl/txm_pkg.sv
package txm_pkg;
  localparam int unsigned LANE_W = 10;
  localparam logic [LANE_W-1:0] IDLE_LANE = 10'h1BC;
endpackage

// File: rtl/txm_rst_sync.sv
module txm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n = sync_q;
endmodule

// File: rtl/txm_gray_sync.sv
module txm_gray_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_gray,
  output logic [WIDTH-1:0] dst_gray
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= (s == 0) ? src_gray : stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dst_gray = stage_q[STAGES-1];
endmodule

// File: rtl/txm_wr_side.sv
module txm_wr_side
  import txm_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  parameter int unsigned AW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_valid,
  input  logic [BYTES*8-1:0]      wr_data,
  input  logic [BYTES-1:0]        wr_ctl,
  input  logic [BYTES-1:0]        wr_fnd,
  input  logic [AW:0]             rd_gray_sync,
  input  logic [AW-1:0]           rd_addr,
  output logic [BYTES*LANE_W-1:0] rd_word,
  output logic [AW:0]             wr_gray,
  output logic                    ovf
);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam int unsigned WORD_W = BYTES * LANE_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] packed_word;
  logic [AW:0]       wr_bin_q, wr_bin_d, wr_gray_d;
  logic              full, push, ovf_d;

  // Slot b holds the b-th byte sent: most significant byte in slot 0.
  for (genvar b = 0; b < BYTES; b++) begin : g_pack
    assign packed_word[b*LANE_W +: LANE_W] =
      {wr_fnd[BYTES-1-b], wr_ctl[BYTES-1-b], wr_data[(BYTES-1-b)*8 +: 8]};
  end

  always_comb begin
    full      = (wr_gray == {~rd_gray_sync[AW:AW-1], rd_gray_sync[AW-2:0]});
    push      = wr_valid & ~full;
    wr_bin_d  = wr_bin_q + {{AW{1'b0}}, push};
    wr_gray_d = wr_bin_d ^ (wr_bin_d >> 1);
    ovf_d     = ovf | (wr_valid & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin_q <= '0;
      wr_gray  <= '0;
      ovf      <= 1'b0;
    end else begin
      wr_bin_q <= wr_bin_d;
      wr_gray  <= wr_gray_d;
      ovf      <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_bin_q[AW-1:0]] <= packed_word;
    end
  end

  assign rd_word = mem[rd_addr];

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full) |=> $stable(wr_bin_q)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R6
endmodule

// File: rtl/txm_rd_side.sv
module txm_rd_side
  import txm_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  parameter int unsigned AW    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW:0]             wr_gray_sync,
  input  logic [BYTES*LANE_W-1:0] rd_word,
  output logic [AW-1:0]           rd_addr,
  output logic [AW:0]             rd_gray,
  output logic [LANE_W-1:0]       lane,
  output logic                    udf
);
  localparam int unsigned PW     = $clog2(BYTES);
  localparam int unsigned WORD_W = BYTES * LANE_W;

  logic [PW-1:0]     phase_q, phase_d;
  logic [WORD_W-1:0] hold_q;
  logic [AW:0]       rd_bin_q, rd_bin_d, rd_gray_d;
  logic [LANE_W-1:0] lane_d;
  logic              streaming_q, streaming_d, udf_d;
  logic              empty, at_boundary, pop;

  always_comb begin
    empty       = (rd_gray == wr_gray_sync);
    at_boundary = (phase_q == '0);
    pop         = at_boundary & ~empty;
    phase_d     = (pop | ~at_boundary) ? phase_q + 1'b1 : phase_q;
    rd_bin_d    = rd_bin_q + {{AW{1'b0}}, pop};
    rd_gray_d   = rd_bin_d ^ (rd_bin_d >> 1);
    if (pop) begin
      lane_d = rd_word[0 +: LANE_W];
    end else if (!at_boundary) begin
      lane_d = hold_q[int'(phase_q)*LANE_W +: LANE_W];
    end else begin
      lane_d = IDLE_LANE;
    end
    streaming_d = pop ? 1'b1 : ((at_boundary & empty) ? 1'b0 : streaming_q);
    udf_d       = udf | (at_boundary & empty & streaming_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= '0;
      rd_bin_q    <= '0;
      rd_gray     <= '0;
      lane        <= IDLE_LANE;
      streaming_q <= 1'b0;
      udf         <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      rd_bin_q    <= rd_bin_d;
      rd_gray     <= rd_gray_d;
      lane        <= lane_d;
      streaming_q <= streaming_d;
      udf         <= udf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (pop) begin
      hold_q <= rd_word;
    end
  end

  assign rd_addr = rd_bin_q[AW-1:0];

  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && empty) |=> (lane == IDLE_LANE)); // R4
  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_boundary) |=> (phase_q == PW'($past(phase_q) + 1'b1))); // R3
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    udf |=> udf); // R7
endmodule

// File: rtl/txm_word_to_byte.sv
module txm_word_to_byte
  import txm_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  parameter int unsigned AW    = 3
) (
  input  logic               wr_clk,
  input  logic               wr_arst_n,
  input  logic               wr_valid,
  input  logic [BYTES*8-1:0] wr_data,
  input  logic [BYTES-1:0]   wr_ctl,
  input  logic [BYTES-1:0]   wr_fnd,
  input  logic               byte_clk,
  input  logic               byte_arst_n,
  output logic [LANE_W-1:0]  lane_out,
  output logic               ovf_flag,
  output logic               udf_flag
);
  localparam int unsigned WORD_W = BYTES * LANE_W;

  logic              wr_rst_n, rd_rst_n;
  logic [AW:0]       wr_gray, wr_gray_rs, rd_gray, rd_gray_ws;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_word;

  txm_rst_sync u_wr_rst (.clk(wr_clk),   .arst_n(wr_arst_n),   .rst_n(wr_rst_n));
  txm_rst_sync u_rd_rst (.clk(byte_clk), .arst_n(byte_arst_n), .rst_n(rd_rst_n));

  txm_gray_sync #(.WIDTH(AW+1), .STAGES(2)) u_sync_to_rd (
    .clk(byte_clk), .rst_n(rd_rst_n), .src_gray(wr_gray), .dst_gray(wr_gray_rs));
  txm_gray_sync #(.WIDTH(AW+1), .STAGES(2)) u_sync_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .src_gray(rd_gray), .dst_gray(rd_gray_ws));

  txm_wr_side #(.BYTES(BYTES), .AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ctl(wr_ctl), .wr_fnd(wr_fnd), .rd_gray_sync(rd_gray_ws),
    .rd_addr(rd_addr), .rd_word(rd_word), .wr_gray(wr_gray), .ovf(ovf_flag));

  txm_rd_side #(.BYTES(BYTES), .AW(AW)) u_rd (
    .clk(byte_clk), .rst_n(rd_rst_n), .wr_gray_sync(wr_gray_rs),
    .rd_word(rd_word), .rd_addr(rd_addr), .rd_gray(rd_gray),
    .lane(lane_out), .udf(udf_flag));
endmodule

// File: tb/txm_word_to_byte_bench.sv
module txm_word_to_byte_bench;
  localparam logic [9:0] IDLE = 10'h1BC;
  localparam int NVEC = 6;
  // Each entry: {data[31:0], ctl[3:0], fnd[3:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    40'h0123456781, 40'h89ABCDEF5A, 40'hFFFFFFFF0F,
    40'h00000000F0, 40'hBC3CBC7C58, 40'h5A5AA5A5A5
  };

  logic       wr_clk = 1'b0, byte_clk = 1'b0;
  logic       wr_arst_n = 1'b0, byte_arst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_ctl = '0, wr_fnd = '0;
  logic [9:0] lane_out;
  logic       ovf_flag, udf_flag;

  int checks = 0, errors = 0;
  logic [9:0] cap [512];
  logic       cap_udf [512];
  int         cap_n = 0;
  bit         cap_on = 1'b0;

  txm_word_to_byte u_txm_word_to_byte (
    .wr_clk(wr_clk), .wr_arst_n(wr_arst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ctl(wr_ctl), .wr_fnd(wr_fnd),
    .byte_clk(byte_clk), .byte_arst_n(byte_arst_n),
    .lane_out(lane_out), .ovf_flag(ovf_flag), .udf_flag(udf_flag));

  always #2.5 byte_clk = ~byte_clk;
  initial begin
    #1;
    forever #10 wr_clk = ~wr_clk;
  end

  always @(negedge byte_clk) begin
    if (cap_on && cap_n < 512) begin
      cap[cap_n]     = lane_out;
      cap_udf[cap_n] = udf_flag;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_lane(input logic [39:0] w, input int j);
    int idx = 3 - j;
    return {w[idx], w[4+idx], w[8+idx*8 +: 8]};
  endfunction

  function automatic logic [39:0] ovf_word(input int i);
    return {32'h10203040 + i * 32'h01010101, 4'(i), ~4'(i)};
  endfunction

  task automatic put_word(input logic [39:0] w);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data  = w[39:8];
    wr_ctl   = w[7:4];
    wr_fnd   = w[3:0];
  endtask

  // Checks the captured stream against n words from the table (sel 0) or overflow set.
  task automatic check_stream(input int n, input bit sel);
    int s = -1;
    for (int i = 0; i < cap_n; i++) begin
      if (s < 0 && cap[i] != IDLE) s = i;
    end
    chk(s >= 0, "R3 stream start", 32'(s), 32'd0);
    if (s >= 0) begin
      for (int k = 0; k < 4 * n; k++) begin
        logic [39:0] w = sel ? ovf_word(k / 4) : VEC[k / 4];
        logic [9:0]  e = exp_lane(w, k % 4);
        chk(cap[s + k] == e, "R1 R2 R3 R5 lane", 32'(cap[s + k]), 32'(e));
      end
      chk(cap[s + 4 * n] == IDLE, "R4 idle after stream", 32'(cap[s + 4 * n]), 32'(IDLE));
      chk(cap_udf[s + 4 * n - 1] == 1'b0, "R7 no gap flag mid-stream",
          32'(cap_udf[s + 4 * n - 1]), 32'd0);
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reset state: R5, R8
    repeat (10) @(negedge byte_clk);
    chk(lane_out == IDLE, "R5 lane idle in reset", 32'(lane_out), 32'(IDLE));
    chk(ovf_flag == 1'b0, "R8 ovf after reset", 32'(ovf_flag), 32'd0);
    chk(udf_flag == 1'b0, "R8 udf after reset", 32'(udf_flag), 32'd0);
    wr_arst_n = 1'b1;
    byte_arst_n = 1'b1;
    repeat (20) @(negedge byte_clk);
    chk(lane_out == IDLE, "R4 idle when empty", 32'(lane_out), 32'(IDLE));
    chk(udf_flag == 1'b0, "R7 no gap before first word", 32'(udf_flag), 32'd0);

    // Table-driven back-to-back stream
    cap_n = 0;
    cap_on = 1'b1;
    for (int i = 0; i < NVEC; i++) put_word(VEC[i]);
    @(negedge wr_clk);
    wr_valid = 1'b0;
    repeat (80) @(negedge byte_clk);
    cap_on = 1'b0;
    check_stream(NVEC, 1'b0);
    chk(udf_flag == 1'b1, "R7 gap flag after stream end", 32'(udf_flag), 32'd1);
    chk(ovf_flag == 1'b0, "R6 no overflow at matched rate", 32'(ovf_flag), 32'd0);

    // Overflow: byte side held in reset while nine words are written
    wr_arst_n = 1'b0;
    byte_arst_n = 1'b0;
    repeat (4) @(negedge wr_clk);
    chk(udf_flag == 1'b0, "R8 udf cleared by reset", 32'(udf_flag), 32'd0);
    wr_arst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    for (int i = 0; i < 9; i++) begin
      if (i == 8) chk(ovf_flag == 1'b0, "R6 eight words fit", 32'(ovf_flag), 32'd0);
      put_word(ovf_word(i));
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
    @(negedge wr_clk);
    chk(ovf_flag == 1'b1, "R6 ninth write flags overflow", 32'(ovf_flag), 32'd1);
    cap_n = 0;
    cap_on = 1'b1;
    byte_arst_n = 1'b1;
    repeat (80) @(negedge byte_clk);
    cap_on = 1'b0;
    check_stream(8, 1'b1);
    chk(ovf_flag == 1'b1, "R6 overflow stays set", 32'(ovf_flag), 32'd1);
    chk(udf_flag == 1'b1, "R7 gap after drained FIFO", 32'(udf_flag), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule